// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes received Ethernet frames from a byte-wide MAC receive stream and stores them in buffers described by a ring of descriptors. The descriptors sit in a small register memory inside the block. Each entry holds a 16-bit status word, a 16-bit length and a buffer pointer. Software arms an entry through the host port by setting its empty flag and giving it a buffer pointer. At the first byte of each frame the engine reads the entry at the ring index. If the entry is empty, the engine writes the payload bytes to `pointer + offset` through a one-byte memory write port. On the last byte it closes the entry: it clears the empty flag, sets the last flag, records the byte count (the FCS included) and any error flags, and pulses two interrupt events.

If the entry at the ring index is not empty, the frame is thrown away and the engine stalls. It keeps dropping every frame until a write strobe on the poll-restart input makes it look at the ring again. Deasserting the enable input, or reset, puts the ring index back at the programmed base entry.

Top module: `rxbd_ring_engine`

## Requirements
- R1: During reset or while `rx_en` is low, `ring_idx` is loaded with `desc_base`, `stalled` is 0 and no memory write or event is produced. When `rx_en` is high again, the next frame goes into the entry at `desc_base`.
- R2: A frame that starts on an empty entry writes byte k to `mem_addr = pointer + k`. The write appears on the memory port in the cycle after the byte is presented.
- R3: On the last byte, the engine writes the closing status and length in the same clock edge. The closing status has empty (bit 15) cleared, last (bit 13) set and wrap (bit 14) kept. The length is the count of all bytes in the frame, the 4 FCS bytes included.
- R4: Each closed frame raises `evt_frame` (frame-received, event bit 25) and `evt_buf` (buffer-received, event bit 24) for exactly one cycle, in the cycle after the last byte.
- R5: After a close, `ring_idx` moves to `desc_base` if the closed entry had wrap set. Otherwise it moves to the next entry, modulo the ring size. It changes at no other time while enabled.
- R6: A closed length above 1518 sets too-long (bit 4). A closed length below 64 sets too-short (bit 5). Lengths from 64 to 1518 set neither flag.
- R7: No byte at an offset of 1520 or more is written to memory. The length still counts every byte received.
- R8: The error inputs map to status bits as follows: CRC error to bit 0, non-octet frame to bit 1, FIFO overrun to bit 2, late collision to bit 3. Error flags are cleared at the start of each frame, so none carries over from an earlier frame.
- R9: A frame whose first byte finds the current entry not empty is dropped whole: no memory write, no descriptor change, no event, and `ring_idx` does not move. `stalled` rises, and every later frame is also dropped while `stalled` is high.
- R10: A one-cycle pulse on `poll_kick` clears `stalled` at the next edge. The frame after that is checked against the descriptor again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; low holds the engine at the base entry |
| desc_base | input | 3 | Index of the first ring entry |
| poll_kick | input | 1 | Write strobe that restarts descriptor polling |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_err_nonoct | input | 1 | Frame not a whole number of octets |
| rx_err_crc | input | 1 | Frame check sequence mismatch |
| rx_err_ovr | input | 1 | MAC receive FIFO overrun |
| rx_err_lcol | input | 1 | Late collision seen |
| host_we | input | 1 | Host descriptor write strobe |
| host_widx | input | 3 | Host write entry index |
| host_wstatus | input | 16 | Status word to write |
| host_wlen | input | 16 | Length to write |
| host_wptr | input | 16 | Buffer pointer to write |
| host_ridx | input | 3 | Host read entry index |
| host_rstatus | output | 16 | Status of the addressed entry |
| host_rlen | output | 16 | Length of the addressed entry |
| host_rptr | output | 16 | Buffer pointer of the addressed entry |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | 16 | Payload byte address |
| mem_wdata | output | 8 | Payload byte |
| evt_frame | output | 1 | Full-frame-received event pulse |
| evt_buf | output | 1 | Buffer-received event pulse |
| stalled | output | 1 | Polling halted on a non-empty entry |
| ring_idx | output | 3 | Current ring entry |

## Verification
Descriptor status and length change on the edge that takes the last byte, so they are read through the combinational host port at the following falling edge. `mem_we`, `evt_frame` and `evt_buf` are registered, so each is due one cycle after the byte that caused it. A falling-edge monitor counts writes and events over the whole frame, and the counts are compared only after two idle cycles have passed. `stalled` and `ring_idx` are checked one falling edge after the kick or enable change that moves them.

// File: rtl/rxbd_pkg.sv
// Shared definitions for the receive descriptor ring engine.
// Assumes a 16-bit descriptor status word with the bit layout below.
package rxbd_pkg;
    localparam int ST_EMPTY  = 15;
    localparam int ST_WRAP   = 14;
    localparam int ST_LAST   = 13;
    localparam int ST_SHORT  = 5;
    localparam int ST_LONG   = 4;
    localparam int ST_LCOL   = 3;
    localparam int ST_OVR    = 2;
    localparam int ST_NONOCT = 1;
    localparam int ST_CRC    = 0;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_FILL = 2'd1,
        ENG_DROP = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic nonoct;
        logic crc;
        logic ovr;
        logic lcol;
    } rx_err_t;
endpackage

// File: rtl/rxbd_desc_store.sv
// Descriptor register memory: one host write port, one engine close port.
// The engine port wins when both address the same entry in one cycle.
// Assumes NUM_DESC entries addressed by IDX_W-bit indices.
module rxbd_desc_store #(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3,
    parameter int PTR_W    = 16,
    parameter int LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  logic [15:0]      host_wstatus,
    input  logic [LEN_W-1:0] host_wlen,
    input  logic [PTR_W-1:0] host_wptr,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [15:0]      host_rstatus,
    output logic [LEN_W-1:0] host_rlen,
    output logic [PTR_W-1:0] host_rptr,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [15:0]      eng_wstatus,
    input  logic [LEN_W-1:0] eng_wlen,
    output logic             eng_empty,
    output logic             eng_wrap,
    output logic [PTR_W-1:0] eng_rptr
);
    import rxbd_pkg::*;

    logic [15:0]      st_q  [NUM_DESC];
    logic [LEN_W-1:0] len_q [NUM_DESC];
    logic [PTR_W-1:0] ptr_q [NUM_DESC];

    // Entry update: engine close has priority over the host write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_DESC; i++) begin
            if (!rst_n) begin
                st_q[i]  <= '0;
                len_q[i] <= '0;
                ptr_q[i] <= '0;
            end else if (eng_we && eng_idx == IDX_W'(i)) begin
                st_q[i]  <= eng_wstatus;
                len_q[i] <= eng_wlen;
            end else if (host_we && host_widx == IDX_W'(i)) begin
                st_q[i]  <= host_wstatus;
                len_q[i] <= host_wlen;
                ptr_q[i] <= host_wptr;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        host_rstatus = st_q[host_ridx];
        host_rlen    = len_q[host_ridx];
        host_rptr    = ptr_q[host_ridx];
        eng_empty    = st_q[eng_idx][ST_EMPTY];
        eng_wrap     = st_q[eng_idx][ST_WRAP];
        eng_rptr     = ptr_q[eng_idx];
    end
endmodule

// File: rtl/rxbd_status_gen.sv
// Builds the closing status word from the final length and error flags.
// Assumes the length already includes the FCS bytes.
module rxbd_status_gen #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64
) (
    input  logic             wrap,
    input  logic [LEN_W-1:0] len,
    input  rxbd_pkg::rx_err_t err,
    output logic [15:0]      status
);
    import rxbd_pkg::*;

    // Closing word: owned by software, last in frame, error flags set.
    always_comb begin
        status            = '0;
        status[ST_EMPTY]  = 1'b0;
        status[ST_WRAP]   = wrap;
        status[ST_LAST]   = 1'b1;
        status[ST_LONG]   = len > LEN_W'(MAX_FRAME);
        status[ST_SHORT]  = len < LEN_W'(MIN_FRAME);
        status[ST_CRC]    = err.crc;
        status[ST_NONOCT] = err.nonoct;
        status[ST_OVR]    = err.ovr;
        status[ST_LCOL]   = err.lcol;
    end
endmodule

// File: rtl/rxbd_ring_engine.sv
// Receive descriptor ring engine: fills empty descriptors with MAC frames,
// closes them on end of frame, and stalls on a non-empty descriptor until
// it is kicked. Assumes error flags are valid on any byte of the frame.
module rxbd_ring_engine #(
    parameter int NUM_DESC  = 8,
    parameter int PTR_W     = 16,
    parameter int LEN_W     = 16,
    parameter int BUF_BYTES = 1520,
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64,
    localparam int IDX_W    = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [IDX_W-1:0] desc_base,
    input  logic             poll_kick,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_err_nonoct,
    input  logic             rx_err_crc,
    input  logic             rx_err_ovr,
    input  logic             rx_err_lcol,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  logic [15:0]      host_wstatus,
    input  logic [LEN_W-1:0] host_wlen,
    input  logic [PTR_W-1:0] host_wptr,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [15:0]      host_rstatus,
    output logic [LEN_W-1:0] host_rlen,
    output logic [PTR_W-1:0] host_rptr,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             evt_frame,
    output logic             evt_buf,
    output logic             stalled,
    output logic [IDX_W-1:0] ring_idx
);
    import rxbd_pkg::*;

    eng_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] cnt_q;
    rx_err_t          err_q;
    logic             stalled_q;

    logic             run;
    logic             eng_empty, eng_wrap;
    logic [PTR_W-1:0] eng_rptr;
    logic             take, close, in_buf;
    logic [LEN_W-1:0] offs, len_next;
    rx_err_t          err_in, err_next;
    logic [IDX_W-1:0] idx_after;
    logic [15:0]      close_status;

    rxbd_desc_store #(
        .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_widx(host_widx), .host_wstatus(host_wstatus),
        .host_wlen(host_wlen), .host_wptr(host_wptr),
        .host_ridx(host_ridx), .host_rstatus(host_rstatus),
        .host_rlen(host_rlen), .host_rptr(host_rptr),
        .eng_we(close), .eng_idx(idx_q), .eng_wstatus(close_status),
        .eng_wlen(len_next), .eng_empty(eng_empty), .eng_wrap(eng_wrap),
        .eng_rptr(eng_rptr)
    );

    rxbd_status_gen #(
        .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)
    ) u_status (
        .wrap(eng_wrap), .len(len_next), .err(err_next), .status(close_status)
    );

    // Byte acceptance, offset, error accumulation and next ring entry.
    always_comb begin
        run       = rst_n && rx_en;
        offs      = (state_q == ENG_IDLE) ? '0 : cnt_q;
        len_next  = (offs == '1) ? offs : offs + 1'b1;
        take      = run && rx_valid &&
                    ((state_q == ENG_FILL) ||
                     (state_q == ENG_IDLE && !stalled_q && eng_empty));
        close     = take && rx_eof;
        in_buf    = offs < LEN_W'(BUF_BYTES);
        err_in    = '{nonoct: rx_err_nonoct, crc: rx_err_crc,
                      ovr: rx_err_ovr, lcol: rx_err_lcol};
        err_next  = ((state_q == ENG_IDLE) ? rx_err_t'('0) : err_q) | err_in;
        if (eng_wrap)
            idx_after = desc_base;
        else if (idx_q == IDX_W'(NUM_DESC - 1))
            idx_after = '0;
        else
            idx_after = idx_q + 1'b1;
    end

    // Frame state machine, ring index and stall flag.
    always_ff @(posedge clk) begin
        if (!run) begin
            state_q   <= ENG_IDLE;
            idx_q     <= desc_base;
            cnt_q     <= '0;
            err_q     <= '0;
            stalled_q <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: if (rx_valid) begin
                    if (take) begin
                        cnt_q   <= len_next;
                        err_q   <= err_next;
                        state_q <= rx_eof ? ENG_IDLE : ENG_FILL;
                    end else begin
                        stalled_q <= 1'b1;
                        state_q   <= rx_eof ? ENG_IDLE : ENG_DROP;
                    end
                end
                ENG_FILL: if (rx_valid) begin
                    cnt_q   <= len_next;
                    err_q   <= err_next;
                    state_q <= rx_eof ? ENG_IDLE : ENG_FILL;
                end
                default: if (rx_valid && rx_eof) state_q <= ENG_IDLE;
            endcase
            if (close) idx_q <= idx_after;
            if (poll_kick) stalled_q <= 1'b0;
        end
    end

    // Registered memory write port and event pulses.
    always_ff @(posedge clk) begin
        if (!run) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            evt_frame <= 1'b0;
            evt_buf   <= 1'b0;
        end else begin
            mem_we    <= take && in_buf;
            mem_addr  <= eng_rptr + PTR_W'(offs);
            mem_wdata <= rx_data;
            evt_frame <= close;
            evt_buf   <= close;
        end
    end

    assign stalled  = stalled_q;
    assign ring_idx = idx_q;
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
// Property checker for the receive descriptor ring engine, bound to the top.
// Assumes reset is held for at least one clock at start.
module rxbd_ring_engine_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic [IDX_W-1:0] desc_base,
    input logic             poll_kick,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic [IDX_W-1:0] ring_idx,
    input logic             stalled,
    input logic             mem_we,
    input logic             evt_frame,
    input logic             evt_buf
);
    AST_IDX_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_en) |-> ring_idx == $past(desc_base)); // R1
    AST_EVT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> $past(rx_valid && rx_eof)); // R4
    AST_IDX_MOVES_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en) && ring_idx != $past(ring_idx)) |-> evt_buf); // R5
    AST_NO_WRITE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> !mem_we); // R9
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        poll_kick |=> !stalled); // R10
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .desc_base(desc_base),
    .poll_kick(poll_kick), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .ring_idx(ring_idx), .stalled(stalled), .mem_we(mem_we),
    .evt_frame(evt_frame), .evt_buf(evt_buf)
);

// File: tb/rxbd_ring_engine_bench.sv
`timescale 1ns/1ps
// Directed bench for the receive descriptor ring engine.
module rxbd_ring_engine_bench;
    localparam logic [15:0] S_EMPTY = 16'h8000, S_WRAP = 16'h4000, S_LAST = 16'h2000;
    localparam logic [15:0] S_SHORT = 16'h0020, S_LONG = 16'h0010, S_LCOL = 16'h0008;
    localparam logic [15:0] S_OVR = 16'h0004, S_NONOCT = 16'h0002, S_CRC = 16'h0001;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, rx_en, poll_kick, rx_valid, rx_eof;
    logic [2:0] desc_base, host_widx, host_ridx, ring_idx;
    logic [7:0] rx_data, mem_wdata;
    logic e_nonoct, e_crc, e_ovr, e_lcol;
    logic host_we;
    logic [15:0] host_wstatus, host_wlen, host_wptr, host_rstatus, host_rlen, host_rptr;
    logic mem_we, evt_frame, evt_buf, stalled;
    logic [15:0] mem_addr;

    rxbd_ring_engine u_rxbd_ring_engine (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .desc_base(desc_base),
        .poll_kick(poll_kick), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_err_nonoct(e_nonoct), .rx_err_crc(e_crc),
        .rx_err_ovr(e_ovr), .rx_err_lcol(e_lcol),
        .host_we(host_we), .host_widx(host_widx), .host_wstatus(host_wstatus),
        .host_wlen(host_wlen), .host_wptr(host_wptr), .host_ridx(host_ridx),
        .host_rstatus(host_rstatus), .host_rlen(host_rlen), .host_rptr(host_rptr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .evt_frame(evt_frame), .evt_buf(evt_buf), .stalled(stalled),
        .ring_idx(ring_idx)
    );

    int n_chk = 0, n_fail = 0;
    int wr_cnt, wr_bad, max_off, evtf_cnt, evtb_cnt;
    logic [15:0] exp_base = '0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: counts writes and events, checks byte data against offset.
    always @(negedge clk) begin
        logic [15:0] off;
        off = mem_addr - exp_base;
        if (mem_we) begin
            wr_cnt++;
            if (mem_wdata != (off[7:0] ^ 8'h5A)) wr_bad++;
            if (int'(off) > max_off) max_off = int'(off);
        end
        if (evt_frame) evtf_cnt++;
        if (evt_buf) evtb_cnt++;
    end

    task automatic arm(input logic [2:0] idx, input logic [15:0] st, input logic [15:0] ptr);
        @(negedge clk);
        host_we = 1'b1; host_widx = idx; host_wstatus = st; host_wlen = '0; host_wptr = ptr;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic send(input int n, input logic [15:0] base, input logic [3:0] errs);
        exp_base = base;
        wr_cnt = 0; wr_bad = 0; max_off = -1; evtf_cnt = 0; evtb_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(i) ^ 8'h5A; rx_eof = (i == n - 1);
            {e_nonoct, e_crc, e_ovr, e_lcol} = (i == n - 1) ? errs : 4'b0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; {e_nonoct, e_crc, e_ovr, e_lcol} = 4'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_desc(input logic [2:0] idx);
        host_ridx = idx;
        #0.5;
    endtask

    task automatic t_reset();
        chk("R1", "ring_idx after reset", ring_idx, 0);
        chk("R1", "stalled after reset", stalled, 0);
        chk("R1", "mem_we after reset", mem_we, 0);
        chk("R1", "evt after reset", evt_frame | evt_buf, 0);
    endtask

    task automatic t_basic();
        arm(3'd0, S_EMPTY, 16'h0100);
        send(100, 16'h0100, 4'b0);
        chk("R2", "write count", wr_cnt, 100);
        chk("R2", "bad bytes", wr_bad, 0);
        chk("R2", "last offset", max_off, 99);
        read_desc(3'd0);
        chk("R3", "closed status", host_rstatus, S_LAST);
        chk("R3", "closed length", host_rlen, 100);
        chk("R4", "frame events", evtf_cnt, 1);
        chk("R4", "buffer events", evtb_cnt, 1);
        chk("R5", "index after close", ring_idx, 1);
    endtask

    task automatic t_wrap_short();
        arm(3'd1, S_EMPTY | S_WRAP, 16'h0800);
        send(64, 16'h0800, 4'b0);
        read_desc(3'd1);
        chk("R6", "64-byte status keeps wrap, no length flag", host_rstatus, S_WRAP | S_LAST);
        chk("R5", "index after wrap", ring_idx, 0);
        arm(3'd0, S_EMPTY, 16'h1000);
        send(63, 16'h1000, 4'b0);
        read_desc(3'd0);
        chk("R6", "63-byte too-short", host_rstatus, S_LAST | S_SHORT);
        chk("R3", "63-byte length", host_rlen, 63);
    endtask

    task automatic t_errors();
        arm(3'd1, S_EMPTY, 16'h2000);
        send(70, 16'h2000, 4'b0101);
        read_desc(3'd1);
        chk("R8", "crc and late collision", host_rstatus, S_LAST | S_CRC | S_LCOL);
        arm(3'd2, S_EMPTY, 16'h3000);
        send(70, 16'h3000, 4'b1010);
        read_desc(3'd2);
        chk("R8", "non-octet and overrun", host_rstatus, S_LAST | S_NONOCT | S_OVR);
        arm(3'd3, S_EMPTY, 16'h3800);
        send(70, 16'h3800, 4'b0);
        read_desc(3'd3);
        chk("R8", "flags cleared on next frame", host_rstatus, S_LAST);
    endtask

    task automatic t_long();
        arm(3'd4, S_EMPTY, 16'h4000);
        send(1518, 16'h4000, 4'b0);
        read_desc(3'd4);
        chk("R6", "1518 bytes legal", host_rstatus, S_LAST);
        arm(3'd5, S_EMPTY, 16'h5000);
        send(1519, 16'h5000, 4'b0);
        read_desc(3'd5);
        chk("R6", "1519 bytes too-long", host_rstatus, S_LAST | S_LONG);
        arm(3'd6, S_EMPTY, 16'h6000);
        send(1525, 16'h6000, 4'b0);
        read_desc(3'd6);
        chk("R6", "1525 bytes too-long", host_rstatus, S_LAST | S_LONG);
        chk("R3", "1525 length counted", host_rlen, 1525);
        chk("R7", "writes capped at buffer", wr_cnt, 1520);
        chk("R7", "highest offset", max_off, 1519);
        chk("R5", "index before stall test", ring_idx, 7);
    endtask

    task automatic t_stall();
        send(80, 16'h7000, 4'b0);
        chk("R9", "no writes on busy entry", wr_cnt, 0);
        chk("R9", "no events on busy entry", evtf_cnt, 0);
        chk("R9", "stalled raised", stalled, 1);
        chk("R9", "index held", ring_idx, 7);
        read_desc(3'd7);
        chk("R9", "busy entry untouched", host_rstatus, 0);
        arm(3'd7, S_EMPTY | S_WRAP, 16'h7000);
        send(40, 16'h7000, 4'b0);
        chk("R9", "still dropping while stalled", wr_cnt, 0);
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
        chk("R10", "kick clears stall", stalled, 0);
        send(40, 16'h7000, 4'b0);
        chk("R10", "frame taken after kick", wr_cnt, 40);
        read_desc(3'd7);
        chk("R10", "status after kick", host_rstatus, S_WRAP | S_LAST | S_SHORT);
        chk("R5", "wrap to base 0", ring_idx, 0);
    endtask

    task automatic t_disable();
        @(negedge clk); desc_base = 3'd3; rx_en = 1'b0;
        @(negedge clk);
        chk("R1", "index at new base while disabled", ring_idx, 3);
        chk("R1", "quiet while disabled", mem_we | evt_frame, 0);
        rx_en = 1'b1;
        arm(3'd3, S_EMPTY, 16'h5800);
        send(66, 16'h5800, 4'b0);
        chk("R1", "frame lands at base entry", wr_cnt, 66);
        read_desc(3'd3);
        chk("R1", "base entry closed", host_rstatus, S_LAST);
        chk("R5", "index after base entry", ring_idx, 4);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rx_en = 1'b1; desc_base = '0; poll_kick = 1'b0;
        rx_valid = 1'b0; rx_data = '0; rx_eof = 1'b0;
        {e_nonoct, e_crc, e_ovr, e_lcol} = 4'b0;
        host_we = 1'b0; host_widx = '0; host_wstatus = '0; host_wlen = '0;
        host_wptr = '0; host_ridx = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap_short();
        t_errors();
        t_long();
        t_stall();
        t_disable();
        finish_run();
    end
endmodule